// File: doc/BRIEF.md
# Programmable Reference Clock Divider with Lock Handshake

This block divides a reference clock by an integer held in a control register. Software writes one 32-bit control word through a simple synchronous register port: a write enable, a full-word write data bus, and a combinational read data bus. The divided clock appears as a one-cycle clock-enable pulse, `tick_o`, in the reference domain. Downstream logic uses that pulse to qualify its own registers.

Writing the divisor field does not change the running ratio by itself. A new ratio takes effect only on a write that also sets the load strobe. The lock flag then drops. It rises again once the new ratio has settled, which takes two full output periods.

The word also holds an output enable, a reset request for the downstream domain, and a gate bit for the reference buffer. Parameters choose:
- the width of the divisor field;
- which of two bit positions carries the lock flag;
- an optional remapping of small divisors to bypass;
- a mode in which each load also stops the output.

The lock tracker is a two-state machine:
- LK_LOCKED moves to LK_SETTLE on any load.
- LK_SETTLE restarts itself on a further load.
- LK_SETTLE returns to LK_LOCKED when its cycle counter reaches 2·max(N,1)−1.

Top module: `refdiv_ctl`

## Requirements
- R1: After reset, every control bit and the divisor field read 0, and only the lock flag reads 1. `tick_o` is low, `ref_buf_en_o` is high and `dom_rst_o` is low.
- R2: The requested divisor is taken from write bits 26:4. It reads back in bits 4+DIV_W−1:4, after remapping. A request above 2^DIV_W−1 is stored as 2^DIV_W−1.
- R3: A write without the load strobe (bit 2) changes the stored field only. The output period and the lock flag stay as they were.
- R4: A write with bit 2 set makes the active divisor equal the stored field. Bit 2 reads 1 in the cycle after the write and 0 from the next cycle on. The strobe also restarts the pulse counter.
- R5: While running, `tick_o` is high for one cycle every max(N,1) reference cycles, where N is the active divisor. For N of 0 or 1 it stays high.
- R6: The lock flag reads 0 in the cycle after a strobe write. It reads 1 again exactly 2·max(N,1) cycles after that write, which is within the 4·max(N,1) bound.
- R7: While the enable (bit 0) is 0 or the reset request (bit 1) is 1, the following holds:
  - `tick_o` stays low and the counter is held at zero.
  - When the block runs again, the first pulse comes max(N,1) cycles after the enabling write.
  - The lock flag is unaffected.
- R8: The lock flag is at bit 31 when LOCK_ALT is 0 and at bit 27 when LOCK_ALT is 1. The unused position reads 0.
- R9: Remapping depends on SKIP_MODE:
  - SKIP_MODE 1 stores a request of 1 as 0.
  - SKIP_MODE 2 stores requests of 1 and 2 as 0, and 3 as 4.
  - All other values pass through unchanged.
- R10: With GATE_TO_SET set, a write with bit 2 set stores 0 in the enable bit, whatever bit 0 carries. The output stays stopped until a later write sets the enable.
- R11: `ref_buf_en_o` is the inverse of control bit 28. `dom_rst_o` follows control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write enable |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read-back with the lock flag |
| tick_o | output | 1 | Divided clock-enable pulse |
| ref_buf_en_o | output | 1 | Reference buffer enable (high while bit 28 is 0) |
| dom_rst_o | output | 1 | Reset request to the divided domain |

## Verification
The main function is driven with loaded divisors 0, 1, 2, 5 and 255. These separate the bypass cases from even, odd and full-scale counting, and each one is checked for both pulse spacing and lock latency. A field-only write between two period measurements shows whether the stored field leaks into the running ratio. A halt-and-resume sequence, covering both disable and reset request, shows whether the counter is really held at zero. A second instance with the alternate lock position, the wider bypass remap and load-stops-output mode covers the parameter variants.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int BIT_EN        = 0;
    localparam int BIT_RST       = 1;
    localparam int BIT_LOAD      = 2;
    localparam int FIELD_LSB     = 4;
    localparam int REQ_MSB       = 26;
    localparam int REQ_W         = REQ_MSB - FIELD_LSB + 1;
    localparam int BIT_LOCK_ALT  = 27;
    localparam int BIT_GATE      = 28;
    localparam int BIT_LOCK_MAIN = 31;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_SETTLE = 1'b1
    } lock_state_e;
endpackage

// File: rtl/refdiv_regs.sv
module refdiv_regs
    import refdiv_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SKIP_MODE   = 0,
    parameter bit GATE_TO_SET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic             en_q,
    output logic             rst_q,
    output logic             load_q,
    output logic             gate_q,
    output logic [DIV_W-1:0] field_q,
    output logic [DIV_W-1:0] act_q
);
    localparam int DIV_MAX = (1 << DIV_W) - 1;

    logic [REQ_W-1:0] req;
    logic [DIV_W-1:0] clamped;
    logic [DIV_W-1:0] mapped;
    logic             load_req;
    logic             unused_wr_bits;

    assign req            = wr_data[REQ_MSB:FIELD_LSB];
    assign load_req       = wr_data[BIT_LOAD];
    assign unused_wr_bits = ^{wr_data[31:29], wr_data[27], wr_data[3]};
    assign clamped        = (req > REQ_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : req[DIV_W-1:0];

    generate
        if (SKIP_MODE == 1) begin : g_skip_one
            always_comb mapped = (clamped == DIV_W'(1)) ? '0 : clamped;
        end else if (SKIP_MODE == 2) begin : g_skip_three
            always_comb begin
                if (clamped == DIV_W'(1) || clamped == DIV_W'(2))
                    mapped = '0;
                else if (clamped == DIV_W'(3))
                    mapped = DIV_W'(4);
                else
                    mapped = clamped;
            end
        end else begin : g_plain
            always_comb mapped = clamped;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rst_q   <= 1'b0;
            load_q  <= 1'b0;
            gate_q  <= 1'b0;
            field_q <= '0;
            act_q   <= '0;
        end else begin
            load_q <= 1'b0;
            if (wr_en) begin
                en_q    <= wr_data[BIT_EN] & ~(GATE_TO_SET & load_req);
                rst_q   <= wr_data[BIT_RST];
                load_q  <= load_req;
                gate_q  <= wr_data[BIT_GATE];
                field_q <= mapped;
                if (load_req)
                    act_q <= mapped;
            end
        end
    end
endmodule

// File: rtl/refdiv_count.sv
module refdiv_count #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] eff,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == eff - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (!run || restart) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/refdiv_lock.sv
module refdiv_lock
    import refdiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] eff,
    output logic             locked_o
);
    localparam int LC_W = DIV_W + 1;

    lock_state_e state_q, state_d;
    logic [LC_W-1:0] lcnt_q;
    logic [LC_W-1:0] last;

    assign last = {eff, 1'b0} - LC_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (load) state_d = LK_SETTLE;
            LK_SETTLE: begin
                if (load)                 state_d = LK_SETTLE;
                else if (lcnt_q == last)  state_d = LK_LOCKED;
            end
            default:   state_d = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    lcnt_q <= '0;
        else if (load)                 lcnt_q <= '0;
        else if (state_q == LK_SETTLE) lcnt_q <= lcnt_q + LC_W'(1);
    end

    always_comb locked_o = (state_q == LK_LOCKED);
endmodule

// File: rtl/refdiv_ctl.sv
module refdiv_ctl
    import refdiv_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter bit LOCK_ALT    = 1'b0,
    parameter int SKIP_MODE   = 0,
    parameter bit GATE_TO_SET = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        tick_o,
    output logic        ref_buf_en_o,
    output logic        dom_rst_o
);
    localparam int LOCK_POS = LOCK_ALT ? BIT_LOCK_ALT : BIT_LOCK_MAIN;

    logic             en_q, rst_q, load_q, gate_q, locked;
    logic [DIV_W-1:0] field_q, act_q, eff;
    logic             load, run;

    assign load = wr_en & wr_data[BIT_LOAD];
    assign eff  = (act_q == '0) ? DIV_W'(1) : act_q;
    assign run  = en_q & ~rst_q;

    refdiv_regs #(.DIV_W(DIV_W), .SKIP_MODE(SKIP_MODE), .GATE_TO_SET(GATE_TO_SET)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .en_q(en_q), .rst_q(rst_q), .load_q(load_q), .gate_q(gate_q),
        .field_q(field_q), .act_q(act_q)
    );

    refdiv_count #(.DIV_W(DIV_W)) count_i (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(load), .eff(eff), .tick_o(tick_o)
    );

    refdiv_lock #(.DIV_W(DIV_W)) lock_i (
        .clk(clk), .rst_n(rst_n), .load(load), .eff(eff), .locked_o(locked)
    );

    always_comb begin
        rd_data                      = '0;
        rd_data[BIT_EN]              = en_q;
        rd_data[BIT_RST]             = rst_q;
        rd_data[BIT_LOAD]            = load_q;
        rd_data[FIELD_LSB +: DIV_W]  = field_q;
        rd_data[BIT_GATE]            = gate_q;
        rd_data[LOCK_POS]            = locked;
    end

    assign ref_buf_en_o = ~gate_q;
    assign dom_rst_o    = rst_q;
endmodule

// File: rtl/refdiv_ctl_chk.sv
module refdiv_ctl_chk #(
    parameter int DIV_W    = 8,
    parameter int LOCK_POS = 31
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        tick_o,
    input logic        ref_buf_en_o,
    input logic        dom_rst_o
);
    logic unused_chk;
    assign unused_chk = ^{wr_data, rd_data};

    AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] |=> !rd_data[2]); // R4

    AST_LOAD_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2]) |=> !rd_data[LOCK_POS]); // R6

    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2]) |=> !tick_o); // R4

    AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[0] || rd_data[1]) |=> !tick_o); // R7

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[4 +: DIV_W])); // R3

    AST_BUF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ref_buf_en_o == !$past(wr_data[28]))); // R11

    AST_DRST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dom_rst_o == $past(wr_data[1]))); // R11
endmodule

bind refdiv_ctl refdiv_ctl_chk #(.DIV_W(DIV_W), .LOCK_POS(LOCK_POS)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tick_o(tick_o), .ref_buf_en_o(ref_buf_en_o), .dom_rst_o(dom_rst_o)
);

// File: tb/refdiv_ctl_tb_top.sv
module refdiv_ctl_tb_top;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        a_we, b_we;
    logic [31:0] a_wd, b_wd, a_rd, b_rd;
    logic        a_tick, b_tick, a_buf, b_buf, a_drst, b_drst;
    int n_chk = 0;
    int n_err = 0;

    refdiv_ctl #(.DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(a_we), .wr_data(a_wd), .rd_data(a_rd),
        .tick_o(a_tick), .ref_buf_en_o(a_buf), .dom_rst_o(a_drst));

    refdiv_ctl #(.DIV_W(DW), .LOCK_ALT(1'b1), .SKIP_MODE(2), .GATE_TO_SET(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(b_we), .wr_data(b_wd), .rd_data(b_rd),
        .tick_o(b_tick), .ref_buf_en_o(b_buf), .dom_rst_o(b_drst));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(bit en, bit rs, bit ld, int div, bit gate);
        logic [31:0] w;
        w = '0;
        w[0] = en; w[1] = rs; w[2] = ld;
        w[26:4] = div[22:0];
        w[28] = gate;
        return w;
    endfunction

    task automatic wr(bit sel, logic [31:0] w);
        @(negedge clk);
        if (sel) begin b_we = 1'b1; b_wd = w; end
        else     begin a_we = 1'b1; a_wd = w; end
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
    endtask

    function automatic int fld(logic [31:0] r);
        return int'(r[4 +: DW]);
    endfunction

    task automatic period_chk(string req, int n);
        int c = 0;
        while (!a_tick && c < 1000) begin @(negedge clk); c++; end
        for (int k = 0; k < 3; k++) begin
            c = 0;
            do begin @(negedge clk); c++; end while (!a_tick && c < 1000);
            check(req, c, n);
        end
    endtask

    task automatic first_tick(string req, bit sel, int n);
        int c = 0;
        while (!(sel ? b_tick : a_tick) && c < 1000) begin @(negedge clk); c++; end
        check(req, c, n);
    endtask

    task automatic quiet_chk(string req, bit sel, int cycles);
        int hits = 0;
        @(negedge clk);
        for (int k = 0; k < cycles; k++) begin
            if (sel ? b_tick : a_tick) hits++;
            @(negedge clk);
        end
        check(req, hits, 0);
    endtask

    task automatic t_reset();
        check("R1 read-back", a_rd, 32'h8000_0000);
        check("R1 tick", a_tick, 0);
        check("R1 buf", a_buf, 1);
        check("R1 drst", a_drst, 0);
        check("R8 alt lock position", b_rd, 32'h0800_0000);
    endtask

    task automatic t_divisors();
        int divs[5] = '{0, 1, 2, 5, 255};
        foreach (divs[i]) begin
            int eff = (divs[i] == 0) ? 1 : divs[i];
            int c = 0;
            wr(0, ctl(1, 0, 1, divs[i], 0));
            check("R6 lock drops", a_rd[31], 0);
            while (!a_rd[31] && c < 2000) begin @(negedge clk); c++; end
            check("R6 lock latency", c, 2 * eff);
            check("R6 within bound", c <= 4 * eff, 1);
            period_chk("R5 period", eff);
        end
    endtask

    task automatic t_strobe();
        wr(0, ctl(0, 0, 1, 3, 0));
        check("R4 strobe visible", a_rd[2], 1);
        @(negedge clk);
        check("R4 strobe clears", a_rd[2], 0);
        check("R4 field", fld(a_rd), 3);
    endtask

    task automatic t_no_strobe();
        wr(0, ctl(1, 0, 1, 4, 0));
        period_chk("R5 period 4", 4);
        repeat (10) @(negedge clk);
        wr(0, ctl(1, 0, 0, 6, 0));
        check("R2 field readback", fld(a_rd), 6);
        check("R3 lock kept", a_rd[31], 1);
        period_chk("R3 ratio unchanged", 4);
    endtask

    task automatic t_clamp();
        wr(0, ctl(0, 0, 0, 1000, 0));
        check("R2 clamp 1000", fld(a_rd), 255);
        wr(0, ctl(0, 0, 0, 256, 0));
        check("R2 clamp 256", fld(a_rd), 255);
        wr(0, ctl(0, 0, 0, 254, 0));
        check("R2 pass 254", fld(a_rd), 254);
    endtask

    task automatic t_halt();
        wr(0, ctl(1, 0, 1, 3, 0));
        repeat (8) @(negedge clk);
        period_chk("R5 period 3", 3);
        wr(0, ctl(0, 0, 0, 3, 0));
        quiet_chk("R7 disabled", 0, 20);
        check("R7 lock kept", a_rd[31], 1);
        wr(0, ctl(1, 1, 0, 3, 0));
        quiet_chk("R7 reset request", 0, 20);
        check("R11 drst", a_drst, 1);
        wr(0, ctl(1, 0, 0, 3, 0));
        first_tick("R7 restart", 0, 3);
    endtask

    task automatic t_buf();
        wr(0, ctl(0, 0, 0, 3, 1));
        check("R11 buf gated", a_buf, 0);
        wr(0, ctl(0, 0, 0, 3, 0));
        check("R11 buf on", a_buf, 1);
    endtask

    task automatic t_skip();
        wr(1, ctl(0, 0, 0, 3, 0)); check("R9 3->4", fld(b_rd), 4);
        wr(1, ctl(0, 0, 0, 2, 0)); check("R9 2->0", fld(b_rd), 0);
        wr(1, ctl(0, 0, 0, 1, 0)); check("R9 1->0", fld(b_rd), 0);
        wr(1, ctl(0, 0, 0, 5, 0)); check("R9 5 kept", fld(b_rd), 5);
    endtask

    task automatic t_gate_to_set();
        wr(1, ctl(1, 0, 0, 5, 0));
        check("R10 enable set", b_rd[0], 1);
        wr(1, ctl(1, 0, 1, 5, 0));
        check("R10 enable cleared", b_rd[0], 0);
        check("R8 alt lock drops", b_rd[27], 0);
        quiet_chk("R10 stopped", 1, 30);
        check("R8 alt lock back", b_rd[27], 1);
        check("R8 main position clear", b_rd[31], 0);
        wr(1, ctl(1, 0, 0, 5, 0));
        first_tick("R10 resumes", 1, 5);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; a_we = 1'b0; b_we = 1'b0; a_wd = '0; b_wd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divisors();
        t_strobe();
        t_no_strobe();
        t_clamp();
        t_halt();
        t_buf();
        t_skip();
        t_gate_to_set();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule